// File: doc/BRIEF.md
# Tunable Capacitor Serial Control Receiver

This block is the control side of a 32-step tuning element. A host programs it over three wires: a serial clock, a data line and an enable line. While enable is high, each rising edge of the serial clock pushes one data bit into an 8-bit shift register, most significant bit first. Clock edges are not counted, so a long transfer leaves only the last eight bits in the register. When enable falls, the shifted byte is copied into the active state. That state gives a 5-bit tuning code, where 0 is the lowest capacitance and 31 the highest, and a standby flag.

All three serial lines are asynchronous to the system clock. Each one passes through a synchronizer, and its edges are found in the system clock domain. After each commit, a settle timer holds the ready output low. A wake from standby, and the power-up after reset, use a long settle count. Every other commit uses the shorter switching count. If a committed byte has either of its top two bits set, a sticky error flag is raised, and the byte is still applied.

Top module: `tcap_serial_rx`

## Requirements
- R1: After reset the tuning code is 0, standby is 0, the error flag is 0, and ready stays low for WAKE_CYCLES system clocks before it rises.
- R2: Serial clock edges that arrive while enable is low leave the shift register unchanged.
- R3: Data is sampled on rising serial clock edges, and the first bit received ends up in bit 7 of the byte.
- R4: When more than 8 bits are clocked in one transfer, only the last 8 bits received are committed.
- R5: The tuning code and standby flag keep their old values until enable falls, and then take the shifted byte.
- R6: In the committed byte, bit 5 is the standby flag (1 = standby, 0 = active) and bits 4..0 are the tuning code.
- R7: Every commit that is not a wake from standby drives ready low for SWITCH_CYCLES system clocks. This includes a commit that enters standby and a commit that repeats the current value.
- R8: A commit that takes standby from 1 to 0 drives ready low for WAKE_CYCLES system clocks.
- R9: A committed byte with bit 7 or bit 6 set raises the error flag, which then stays set until reset. The code and standby fields of that byte are still applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ser_clk | input | 1 | Serial clock; data is taken on its rising edge |
| ser_dat | input | 1 | Serial data, most significant bit first |
| ser_en | input | 1 | Transfer enable; a falling edge commits the byte |
| tune_code | output | 5 | Active tuning code |
| standby | output | 1 | Active standby flag |
| ready | output | 1 | High once the settle time after the last commit or reset has run out |
| rsvd_err | output | 1 | Sticky flag: a committed byte had a reserved bit set |

## Verification
The bench sends plain 8-bit transfers with several codes, and these show whether the bit order and field positions are right. An 11-bit transfer separates a receiver that keeps the last eight bits from one that keeps the first eight. Clock pulses sent while enable is low, followed by an empty enable pulse, reveal any shifting that is not gated by enable. A check of the outputs in the middle of a transfer shows whether the commit is held back until enable falls. Sequences of active-to-active, active-to-standby and standby-to-active commits separate the two settle lengths. A byte with reserved bits set, followed by a clean byte, shows whether the error flag is sticky.

// File: rtl/tcap_pkg.sv
package tcap_pkg;
    localparam int TC_WORD_W   = 8;
    localparam int TC_CODE_W   = 5;
    localparam int TC_STBY_POS = 5;
    localparam int TC_RSVD_LO  = 6;

    typedef struct packed {
        logic                 standby;
        logic [TC_CODE_W-1:0] code;
    } tcap_active_t;
endpackage

// File: rtl/tcap_sync.sv
module tcap_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] level
);
    logic [STAGES-1:0][WIDTH-1:0] chain_d, chain_q;

    always_comb begin
        chain_d[0] = din;
        for (int i = 1; i < STAGES; i++) begin
            chain_d[i] = chain_q[i-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= '0;
        end else begin
            chain_q <= chain_d;
        end
    end

    assign level = chain_q[STAGES-1];
endmodule

// File: rtl/tcap_shifter.sv
module tcap_shifter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         shift_en,
    input  logic         bit_in,
    output logic [W-1:0] word
);
    logic [W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (shift_en) begin
            word_d = {word_q[W-2:0], bit_in};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign word = word_q;
endmodule

// File: rtl/tcap_settle.sv
module tcap_settle #(
    parameter int SWITCH_CYCLES = 1200,
    parameter int WAKE_CYCLES   = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    input  logic wake,
    output logic ready
);
    localparam int MAXC = (WAKE_CYCLES > SWITCH_CYCLES) ? WAKE_CYCLES : SWITCH_CYCLES;
    localparam int CW   = $clog2(MAXC + 1);
    localparam logic [CW-1:0] SW_LD = CW'(SWITCH_CYCLES - 1);
    localparam logic [CW-1:0] WK_LD = CW'(WAKE_CYCLES - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          rdy;
    } settle_t;

    settle_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load) begin
            st_d.cnt = wake ? WK_LD : SW_LD;
            st_d.rdy = 1'b0;
        end else if (st_q.cnt != '0) begin
            st_d.cnt = st_q.cnt - 1'b1;
        end else begin
            st_d.rdy = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.cnt <= WK_LD;
            st_q.rdy <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign ready = st_q.rdy;
endmodule

// File: rtl/tcap_serial_rx.sv
module tcap_serial_rx
    import tcap_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int SWITCH_CYCLES = 1200,
    parameter int WAKE_CYCLES   = 7000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 ser_clk,
    input  logic                 ser_dat,
    input  logic                 ser_en,
    output logic [TC_CODE_W-1:0] tune_code,
    output logic                 standby,
    output logic                 ready,
    output logic                 rsvd_err
);
    localparam int LN_CLK = 0;
    localparam int LN_DAT = 1;
    localparam int LN_EN  = 2;

    typedef struct packed {
        logic         clk_prev;
        logic         en_prev;
        tcap_active_t act;
        logic         err;
    } rx_state_t;

    logic [2:0]           sync_lvl;
    logic                 sclk_rise;
    logic                 en_lvl;
    logic                 en_fall;
    logic                 shift_en;
    logic                 wake_sel;
    logic [TC_WORD_W-1:0] shift_word;
    rx_state_t            rx_d, rx_q;

    tcap_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   ({ser_en, ser_dat, ser_clk}),
        .level (sync_lvl)
    );

    assign en_lvl    = sync_lvl[LN_EN];
    assign sclk_rise = sync_lvl[LN_CLK] & ~rx_q.clk_prev;
    assign en_fall   = ~sync_lvl[LN_EN] & rx_q.en_prev;
    assign shift_en  = sclk_rise & en_lvl;

    tcap_shifter #(.W(TC_WORD_W)) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (shift_en),
        .bit_in   (sync_lvl[LN_DAT]),
        .word     (shift_word)
    );

    assign wake_sel = rx_q.act.standby & ~shift_word[TC_STBY_POS];

    tcap_settle #(.SWITCH_CYCLES(SWITCH_CYCLES), .WAKE_CYCLES(WAKE_CYCLES)) u_settle (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (en_fall),
        .wake  (wake_sel),
        .ready (ready)
    );

    always_comb begin
        rx_d          = rx_q;
        rx_d.clk_prev = sync_lvl[LN_CLK];
        rx_d.en_prev  = sync_lvl[LN_EN];
        if (en_fall) begin
            rx_d.act.code    = shift_word[TC_CODE_W-1:0];
            rx_d.act.standby = shift_word[TC_STBY_POS];
            rx_d.err         = rx_q.err | (|shift_word[TC_WORD_W-1:TC_RSVD_LO]);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_q <= '0;
        end else begin
            rx_q <= rx_d;
        end
    end

    assign tune_code = rx_q.act.code;
    assign standby   = rx_q.act.standby;
    assign rsvd_err  = rx_q.err;
endmodule

// File: rtl/tcap_serial_rx_chk.sv
module tcap_serial_rx_chk #(
    parameter int WAKE_CYCLES = 7000
) (
    input logic       clk,
    input logic       rst_n,
    input logic       en_lvl,
    input logic       en_fall,
    input logic [7:0] shift_word,
    input logic [4:0] tune_code,
    input logic       standby,
    input logic       ready,
    input logic       rsvd_err
);
    int unsigned since_rst;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            since_rst <= 0;
        end else if (since_rst < WAKE_CYCLES) begin
            since_rst <= since_rst + 1;
        end
    end

    assert_powerup_low_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (since_rst < WAKE_CYCLES) |-> !ready);

    assert_gate_shift_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !en_lvl |=> $stable(shift_word));

    assert_hold_state_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !en_fall |=> ($stable(tune_code) && $stable(standby)));

    assert_ready_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        en_fall |=> !ready);

    assert_err_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        rsvd_err |=> rsvd_err);
endmodule

bind tcap_serial_rx tcap_serial_rx_chk #(.WAKE_CYCLES(WAKE_CYCLES)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .en_lvl     (en_lvl),
    .en_fall    (en_fall),
    .shift_word (shift_word),
    .tune_code  (tune_code),
    .standby    (standby),
    .ready      (ready),
    .rsvd_err   (rsvd_err)
);

// File: tb/tcap_serial_rx_test.sv
module tcap_serial_rx_test;
    localparam int SW = 40;
    localparam int WK = 150;

    logic clk = 0, rst_n = 0, ser_clk = 0, ser_dat = 0, ser_en = 0;
    logic [4:0] tune_code;
    logic standby, ready, rsvd_err;
    int checks = 0, errors = 0, cycles = 0;

    tcap_serial_rx #(.SYNC_STAGES(2), .SWITCH_CYCLES(SW), .WAKE_CYCLES(WK)) uut (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat), .ser_en(ser_en),
        .tune_code(tune_code), .standby(standby), .ready(ready), .rsvd_err(rsvd_err));

    always #5 clk = ~clk;

    // behavioural reference: input history (index 0 = one edge ago)
    bit h_clk[3], h_dat[3], h_en[3];
    bit [7:0] m_shift = 0;
    bit [4:0] m_code = 0;
    bit m_stby = 0, m_err = 0, m_rdy = 0;
    int m_cnt = WK - 1;

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int k = 0; k < 3; k++) begin h_clk[k] = 0; h_dat[k] = 0; h_en[k] = 0; end
            m_shift = 0; m_code = 0; m_stby = 0; m_err = 0; m_rdy = 0; m_cnt = WK - 1;
        end else begin
            bit rise, fall;
            rise = h_clk[1] && !h_clk[2];
            fall = !h_en[1] && h_en[2];
            if (fall) begin
                m_cnt = (m_stby && !m_shift[5]) ? WK - 1 : SW - 1;
                m_rdy = 0;
                m_code = m_shift[4:0];
                m_stby = m_shift[5];
                if (m_shift[7:6] != 0) m_err = 1;
            end else if (m_cnt > 0) m_cnt--;
            else m_rdy = 1;
            if (rise && h_en[1]) m_shift = {m_shift[6:0], h_dat[1]};
            for (int k = 2; k > 0; k--) begin
                h_clk[k] = h_clk[k-1]; h_dat[k] = h_dat[k-1]; h_en[k] = h_en[k-1];
            end
            h_clk[0] = ser_clk; h_dat[0] = ser_dat; h_en[0] = ser_en;
        end
    end

    always @(negedge clk) begin
        cycles++;
        checks++;
        if (tune_code !== m_code || standby !== m_stby || ready !== m_rdy || rsvd_err !== m_err) begin
            errors++;
            $display("FAIL R6/R7/R8/R9 model cycle %0d: code=%0d stby=%0b rdy=%0b err=%0b expected code=%0d stby=%0b rdy=%0b err=%0b",
                     cycles, tune_code, standby, ready, rsvd_err, m_code, m_stby, m_rdy, m_err);
        end
        if (cycles > 60000) begin
            errors++;
            $display("FAIL watchdog: actual=%0d cycles expected<=60000", cycles);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_bits(input logic [15:0] v, input int n);
        for (int i = n - 1; i >= 0; i--) begin
            ser_dat = v[i];
            wait_cyc(3);
            ser_clk = 1;
            wait_cyc(3);
            ser_clk = 0;
        end
    endtask

    task automatic open_en;
        @(negedge clk); ser_en = 1; wait_cyc(3);
    endtask

    task automatic close_en;
        wait_cyc(3); ser_en = 0; wait_cyc(6);
    endtask

    task automatic send(input logic [15:0] v, input int n);
        open_en(); pulse_bits(v, n); close_en();
    endtask

    initial begin
        wait_cyc(5);
        rst_n = 1;
        wait_cyc(2);
        chk("R1 code", tune_code, 0);
        chk("R1 standby", standby, 0);
        chk("R1 err", rsvd_err, 0);
        chk("R1 ready low", ready, 0);
        wait_cyc(WK);
        chk("R1 ready high", ready, 1);

        send(16'h15, 8);                      // R3 R6: MSB first, fields
        chk("R3 code", tune_code, 5'h15);
        chk("R6 standby", standby, 0);
        chk("R7 ready low", ready, 0);
        wait_cyc(SW + 2);
        chk("R7 ready high", ready, 1);

        open_en(); pulse_bits(16'h0A, 8); wait_cyc(8);
        chk("R5 held mid-transfer", tune_code, 5'h15);
        close_en();
        chk("R5 committed", tune_code, 5'h0A);
        wait_cyc(SW + 2);

        send(16'h51F, 11);                    // R4: last eight bits
        chk("R4 last eight", tune_code, 5'h1F);
        wait_cyc(SW + 2);

        ser_dat = 1;                          // R2: clocks with enable low
        for (int i = 0; i < 8; i++) begin
            wait_cyc(3); ser_clk = 1; wait_cyc(3); ser_clk = 0;
        end
        ser_dat = 0;
        send(16'h0, 0);
        chk("R2 shift untouched", tune_code, 5'h1F);
        chk("R2 standby", standby, 0);
        wait_cyc(SW + 2);

        send(16'h23, 8);                      // standby entry
        chk("R6 standby set", standby, 1);
        chk("R6 code in standby", tune_code, 3);
        wait_cyc(SW + 2);
        chk("R7 standby entry switch time", ready, 1);

        send(16'h04, 8);                      // wake
        chk("R8 woke", standby, 0);
        wait_cyc(SW + 2);
        chk("R8 still settling", ready, 0);
        wait_cyc(WK - SW);
        chk("R8 ready after wake", ready, 1);

        send(16'hC7, 8);                      // reserved bits
        chk("R9 err", rsvd_err, 1);
        chk("R9 code applied", tune_code, 7);
        wait_cyc(SW + 2);
        send(16'h01, 8);
        chk("R9 sticky", rsvd_err, 1);
        chk("R9 code", tune_code, 1);
        wait_cyc(SW + 4);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule